// File: doc/BRIEF.md
# Micro-op Expansion Steering Unit

This block sits after instruction decode. Each cycle it is offered a group of up to four decoded instruction slots. Every slot carries a small predecode code. The code either gives the number of micro-ops the instruction needs (one to three) or says that microcode is required. A per-slot serialize bit forces the microcode path no matter what the code says; upstream logic sets it for serializing conditions, interrupts and exceptions.

Fastpath instructions are expanded by one of four parallel converter lanes. Microcode instructions are handed, with their entry point, to a counter-driven sequencer stub. The stub streams a fixed run of micro-ops that is longer than three.

Both paths produce one shared micro-op format: an opcode, up to two source registers, one destination register, an operand-size code, a microcode flag and an end-of-instruction marker. Micro-ops leave one per cycle, strictly in program order, on a valid/ready port. The input group is held by the sender until the block signals that it has been fully consumed. Instructions behind a microcode instruction therefore wait until its stream has ended.

Top module: `uop_steer`

## Requirements
- R1: While in_valid is low, out_valid and in_ready are low. After reset, the first micro-op presented for a group is the first micro-op of its lowest-numbered valid slot.
- R2: A slot with serialize low and a 2-bit predecode code of 1, 2 or 3 yields exactly that many micro-ops. Micro-op k (k from 0) has opcode equal to the slot opcode plus k, modulo 2^OP_W, and has out_ucode low.
- R3: A slot with its serialize bit high is sent to the microcode path whatever its predecode code, and all of its micro-ops have out_ucode high.
- R4: A slot with predecode code 0, or with serialize high, yields exactly UC_LEN micro-ops (UC_LEN > 3). Micro-op k has opcode equal to the slot entry point plus k, modulo 2^OP_W, and has out_ucode high.
- R5: out_last is high on the final micro-op of each instruction and low on all of its other micro-ops.
- R6: Slots are served in ascending slot order, and slots whose valid bit is low produce no micro-ops. A later slot produces nothing until every micro-op of an earlier slot, including a whole microcode stream, has been accepted.
- R7: in_ready is high only in the cycle in which the final micro-op of the last valid slot is accepted. It is also high in any cycle where in_valid is high and the group has no valid slot.
- R8: While out_valid is high and out_ready is low, every output field stays unchanged into the next cycle, in_ready stays low, and no micro-op is lost or repeated.
- R9: Every micro-op carries the slot's source 2 and destination unchanged. Source 1 is the slot's source 1 on the first fastpath micro-op and on every microcode micro-op. On later fastpath micro-ops, source 1 is the slot's destination (chained result).
- R10: The 3-bit size code is copied unchanged into every micro-op of the slot. The codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8-byte float low half, 4 = 8-byte float high half, 5 = 10-byte float low half and 6 = 10-byte float high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Slot group offered |
| in_ready | output | 1 | Slot group fully consumed this cycle |
| in_slot_vld | input | SLOTS | Per-slot valid bits |
| in_pdec | input | 2*SLOTS | Per-slot predecode: 0 = microcode, 1..3 = micro-op count |
| in_serial | input | SLOTS | Per-slot force-to-microcode bits |
| in_op | input | OP_W*SLOTS | Per-slot base opcode |
| in_src1 | input | REG_W*SLOTS | Per-slot source 1 register |
| in_src2 | input | REG_W*SLOTS | Per-slot source 2 register |
| in_dst | input | REG_W*SLOTS | Per-slot destination register |
| in_size | input | 3*SLOTS | Per-slot operand size code |
| in_entry | input | OP_W*SLOTS | Per-slot microcode entry point |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Consumer accepts micro-op |
| out_op | output | OP_W | Micro-op opcode |
| out_src1 | output | REG_W | Source 1 register |
| out_src2 | output | REG_W | Source 2 register |
| out_dst | output | REG_W | Destination register |
| out_size | output | 3 | Operand size code |
| out_ucode | output | 1 | Micro-op came from the microcode path |
| out_last | output | 1 | Final micro-op of its instruction |

## Verification
The bound checker watches four things on every cycle. It confirms that a stalled micro-op holds still. It confirms that in_ready only comes with an accepted final micro-op. It confirms that the port stays quiet when no group is offered. It counts accepted micro-ops per instruction, so that a fastpath run never exceeds three and a microcode run ends after exactly UC_LEN.

Some properties depend on the offered group and can only be shown by the bench scenarios. These are the exact opcode values, the slot order with gaps in the valid mask, source-1 chaining, size pass-through and the serialize override. The bench sweeps every valid mask against every combination of predecode codes, with a pseudo-random stall pattern, and compares each accepted micro-op with a model built from the requirements.

// File: rtl/uop_pkg.sv
package uop_pkg;

  // predecode code that requests the microcode path
  localparam logic [1:0] PDEC_UCODE = 2'd0;

  // operand size codes carried by every micro-op
  typedef enum logic [2:0] {
    SZ_1B     = 3'd0,
    SZ_2B     = 3'd1,
    SZ_4B     = 3'd2,
    SZ_F8_LO  = 3'd3,
    SZ_F8_HI  = 3'd4,
    SZ_F10_LO = 3'd5,
    SZ_F10_HI = 3'd6
  } opsize_e;

endpackage

// File: rtl/slot_pick.sv
// Finds the first valid slot at or above a start index, and whether another
// valid slot follows it.
module slot_pick #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input  logic [SLOTS-1:0]  vld,
  input  logic [SLOT_W-1:0] from,
  output logic              found,
  output logic [SLOT_W-1:0] idx,
  output logic              more
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    more  = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && (i >= int'(from))) begin
        if (!found) begin
          found = 1'b1;
          idx   = SLOT_W'(i);
        end else begin
          more = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fp_lane.sv
// One fastpath converter lane: route decision and formatting of micro-op
// number 'step' of its instruction.
module fp_lane
  import uop_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int REG_W = 4
) (
  input  logic [1:0]       pdec,
  input  logic             serial,
  input  logic [OP_W-1:0]  op,
  input  logic [REG_W-1:0] src1,
  input  logic [REG_W-1:0] dst,
  input  logic [1:0]       step,
  output logic             to_ucode,
  output logic [1:0]       len,
  output logic [OP_W-1:0]  uop_op,
  output logic [REG_W-1:0] uop_src1
);

  assign to_ucode = serial | (pdec == PDEC_UCODE);
  assign len      = pdec;
  assign uop_op   = op + OP_W'(step);
  // later micro-ops consume the partial result of the previous one
  assign uop_src1 = (step == 2'd0) ? src1 : dst;

endmodule

// File: rtl/ucode_stub.sv
// Counter-driven stand-in for the microcode sequencer.
module ucode_stub #(
  parameter int OP_W   = 8,
  parameter int UC_LEN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [OP_W-1:0] entry,
  output logic [OP_W-1:0] uop_op,
  output logic            done
);

  localparam int CW = $clog2(UC_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done   = (cnt_q == CW'(UC_LEN - 1));
  assign uop_op = entry + OP_W'(cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (done) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uop_steer.sv
module uop_steer
  import uop_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int OP_W   = 8,
  parameter int REG_W  = 4,
  parameter int UC_LEN = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SLOTS-1:0]       in_slot_vld,
  input  logic [2*SLOTS-1:0]     in_pdec,
  input  logic [SLOTS-1:0]       in_serial,
  input  logic [OP_W*SLOTS-1:0]  in_op,
  input  logic [REG_W*SLOTS-1:0] in_src1,
  input  logic [REG_W*SLOTS-1:0] in_src2,
  input  logic [REG_W*SLOTS-1:0] in_dst,
  input  logic [3*SLOTS-1:0]     in_size,
  input  logic [OP_W*SLOTS-1:0]  in_entry,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OP_W-1:0]        out_op,
  output logic [REG_W-1:0]       out_src1,
  output logic [REG_W-1:0]       out_src2,
  output logic [REG_W-1:0]       out_dst,
  output logic [2:0]             out_size,
  output logic                   out_ucode,
  output logic                   out_last
);

  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // state: slot being served and fastpath micro-op index
  logic [SLOT_W-1:0] cur_q, cur_d;
  logic [1:0]        fcnt_q, fcnt_d;
  logic              st_en;

  logic              found, more;
  logic [SLOT_W-1:0] idx;

  slot_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_pick (
    .vld   (in_slot_vld),
    .from  (cur_q),
    .found (found),
    .idx   (idx),
    .more  (more)
  );

  logic [SLOTS-1:0] lane_uc;
  logic [1:0]       lane_len  [SLOTS];
  logic [OP_W-1:0]  lane_op   [SLOTS];
  logic [REG_W-1:0] lane_src1 [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_lane
    fp_lane #(.OP_W(OP_W), .REG_W(REG_W)) i_lane (
      .pdec     (in_pdec[2*s +: 2]),
      .serial   (in_serial[s]),
      .op       (in_op[OP_W*s +: OP_W]),
      .src1     (in_src1[REG_W*s +: REG_W]),
      .dst      (in_dst[REG_W*s +: REG_W]),
      .step     (fcnt_q),
      .to_ucode (lane_uc[s]),
      .len      (lane_len[s]),
      .uop_op   (lane_op[s]),
      .uop_src1 (lane_src1[s])
    );
  end

  logic            is_uc, uc_adv, uc_done, last, fire;
  logic [OP_W-1:0] uc_op;
  opsize_e         sel_size;

  ucode_stub #(.OP_W(OP_W), .UC_LEN(UC_LEN)) i_ucode (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .adv    (uc_adv),
    .entry  (in_entry[OP_W*idx +: OP_W]),
    .uop_op (uc_op),
    .done   (uc_done)
  );

  assign is_uc    = lane_uc[idx];
  assign last     = is_uc ? uc_done : (fcnt_q == (lane_len[idx] - 2'd1));
  assign out_valid = in_valid & found;
  assign fire     = out_valid & out_ready;
  assign uc_adv   = fire & is_uc;
  assign in_ready = in_valid & (~found | (fire & last & ~more));

  assign sel_size  = opsize_e'(in_size[3*idx +: 3]);
  assign out_op    = is_uc ? uc_op : lane_op[idx];
  assign out_src1  = is_uc ? in_src1[REG_W*idx +: REG_W] : lane_src1[idx];
  assign out_src2  = in_src2[REG_W*idx +: REG_W];
  assign out_dst   = in_dst[REG_W*idx +: REG_W];
  assign out_size  = sel_size;
  assign out_ucode = is_uc;
  assign out_last  = last;

  // next state
  assign st_en = in_valid & (~found | fire);
  always_comb begin
    cur_d  = cur_q;
    fcnt_d = fcnt_q;
    if (!found) begin
      cur_d  = '0;
      fcnt_d = '0;
    end else if (last) begin
      fcnt_d = '0;
      cur_d  = more ? (idx + SLOT_W'(1)) : '0;
    end else if (!is_uc) begin
      fcnt_d = fcnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cur_q  <= '0;
      fcnt_q <= '0;
    end else if (st_en) begin
      cur_q  <= cur_d;
      fcnt_q <= fcnt_d;
    end
  end

endmodule

// File: rtl/uop_steer_chk.sv
module uop_steer_chk #(
  parameter int OP_W   = 8,
  parameter int REG_W  = 4,
  parameter int UC_LEN = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OP_W-1:0]  out_op,
  input logic [REG_W-1:0] out_src1,
  input logic [REG_W-1:0] out_src2,
  input logic [REG_W-1:0] out_dst,
  input logic [2:0]       out_size,
  input logic             out_ucode,
  input logic             out_last
);

  logic       fire;
  logic [7:0] run_q;

  assign fire = out_valid & out_ready;

  // accepted micro-ops so far in the current instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (fire) run_q <= out_last ? 8'd0 : run_q + 8'd1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!out_valid && !in_ready));

  a_r7_ready_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && out_valid) |-> (out_ready && out_last));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) &&
      $stable(out_src1) && $stable(out_src2) && $stable(out_dst) &&
      $stable(out_size) && $stable(out_ucode) && $stable(out_last)));

  a_r2_fast_max3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_ucode) |-> (run_q < 8'd3));

  a_r4_uc_len_end: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_ucode && out_last) |-> (run_q == 8'(UC_LEN - 1)));

  a_r4_uc_len_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_ucode && !out_last) |-> (run_q < 8'(UC_LEN - 1)));

endmodule

bind uop_steer uop_steer_chk #(.OP_W(OP_W), .REG_W(REG_W), .UC_LEN(UC_LEN)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .out_src1  (out_src1),
  .out_src2  (out_src2),
  .out_dst   (out_dst),
  .out_size  (out_size),
  .out_ucode (out_ucode),
  .out_last  (out_last)
);

// File: tb/test_uop_steer.sv
module test_uop_steer;

  localparam int SLOTS  = 4;
  localparam int OP_W   = 8;
  localparam int REG_W  = 4;
  localparam int UC_LEN = 5;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic                   in_valid, in_ready, out_valid, out_ready;
  logic [SLOTS-1:0]       in_slot_vld, in_serial;
  logic [2*SLOTS-1:0]     in_pdec;
  logic [OP_W*SLOTS-1:0]  in_op, in_entry;
  logic [REG_W*SLOTS-1:0] in_src1, in_src2, in_dst;
  logic [3*SLOTS-1:0]     in_size;
  logic [OP_W-1:0]        out_op;
  logic [REG_W-1:0]       out_src1, out_src2, out_dst;
  logic [2:0]             out_size;
  logic                   out_ucode, out_last;

  uop_steer #(.SLOTS(SLOTS), .OP_W(OP_W), .REG_W(REG_W), .UC_LEN(UC_LEN)) i_uop_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_pdec(in_pdec), .in_serial(in_serial),
    .in_op(in_op), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
    .in_size(in_size), .in_entry(in_entry), .out_valid(out_valid),
    .out_ready(out_ready), .out_op(out_op), .out_src1(out_src1),
    .out_src2(out_src2), .out_dst(out_dst), .out_size(out_size),
    .out_ucode(out_ucode), .out_last(out_last)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected micro-op stream of one group
  int e_op[32], e_s1[32], e_s2[32], e_dst[32], e_size[32], e_uc[32], e_last[32];
  int n_exp;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_slot_vld = '0; in_pdec = '0; in_serial = '0; in_op = '0; in_entry = '0;
    in_src1 = '0; in_src2 = '0; in_dst = '0; in_size = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready, "R1", "quiet in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk(!out_valid && !in_ready, "R1", "quiet with in_valid low", in_ready, 0);
    @(negedge clk);

    for (int mask = 0; mask < 16; mask++) begin
      for (int combo = 0; combo < 256; combo++) begin
        int g, k, cyc;
        bit done, hold;
        int h_op, h_s1, h_s2, h_dst, h_size, h_uc, h_last;
        g = mask * 256 + combo;
        n_exp = 0;
        for (int s = 0; s < SLOTS; s++) begin
          int pd, op, en, s1, s2, d, sz, len;
          bit ser, uc;
          pd  = (combo >> (2 * s)) & 3;
          ser = ((g % 9) == s);
          op  = (g * 13 + s * 50) & 255;
          en  = (g * 7 + s * 31 + 128) & 255;
          s1  = (g + s) & 15;
          s2  = (g * 3 + s) & 15;
          d   = (g * 5 + s + 1) & 15;
          sz  = (g + s) % 7;
          in_slot_vld[s]          = mask[s];
          in_pdec[2*s +: 2]       = 2'(pd);
          in_serial[s]            = ser;
          in_op[8*s +: 8]         = 8'(op);
          in_entry[8*s +: 8]      = 8'(en);
          in_src1[4*s +: 4]       = 4'(s1);
          in_src2[4*s +: 4]       = 4'(s2);
          in_dst[4*s +: 4]        = 4'(d);
          in_size[3*s +: 3]       = 3'(sz);
          if (mask[s]) begin
            uc  = ser || (pd == 0);
            len = uc ? UC_LEN : pd;
            for (int j = 0; j < len; j++) begin
              e_op[n_exp]   = ((uc ? en : op) + j) & 255;
              e_s1[n_exp]   = (uc || j == 0) ? s1 : d;
              e_s2[n_exp]   = s2;
              e_dst[n_exp]  = d;
              e_size[n_exp] = sz;
              e_uc[n_exp]   = uc;
              e_last[n_exp] = (j == len - 1);
              n_exp++;
            end
          end
        end
        in_valid = 1'b1;
        k = 0; cyc = 0; done = 0; hold = 0;
        h_op = 0; h_s1 = 0; h_s2 = 0; h_dst = 0; h_size = 0; h_uc = 0; h_last = 0;
        while (!done) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          out_ready = lfsr[0] | lfsr[1];
          #1;
          if (hold) begin
            chk(out_valid && out_op == 8'(h_op) && out_src1 == 4'(h_s1) &&
                out_src2 == 4'(h_s2) && out_dst == 4'(h_dst) &&
                out_size == 3'(h_size) && out_ucode == h_uc && out_last == h_last,
                "R8", "stalled micro-op changed (op)", out_op, h_op);
          end
          if (n_exp == 0) begin
            chk(in_ready && !out_valid, "R7", "empty group consumed", in_ready, 1);
            done = 1;
          end else begin
            chk(out_valid, "R6", "micro-op pending", out_valid, 1);
            if (k == 0)
              chk(out_op == 8'(e_op[0]), "R1", "first micro-op of group", out_op, e_op[0]);
            if (out_ready) begin
              chk(out_op == 8'(e_op[k]), e_uc[k] ? "R4" : "R2", "opcode", out_op, e_op[k]);
              chk(out_ucode == e_uc[k], "R3", "path flag", out_ucode, e_uc[k]);
              chk(out_last == e_last[k], "R5", "last marker", out_last, e_last[k]);
              chk(out_src1 == 4'(e_s1[k]) && out_src2 == 4'(e_s2[k]) &&
                  out_dst == 4'(e_dst[k]), "R9", "src1", out_src1, e_s1[k]);
              chk(out_size == 3'(e_size[k]), "R10", "size", out_size, e_size[k]);
              chk(in_ready == (k == n_exp - 1), "R7", "in_ready", in_ready, k == n_exp - 1);
              if (k == n_exp - 1) done = 1;
              k++;
              hold = 0;
            end else begin
              chk(!in_ready, "R8", "in_ready under stall", in_ready, 0);
              hold = 1;
              h_op = out_op; h_s1 = out_src1; h_s2 = out_src2; h_dst = out_dst;
              h_size = out_size; h_uc = out_ucode; h_last = out_last;
            end
          end
          cyc++;
          if (!done && cyc > 200) begin
            chk(0, "R6", "group never completed", k, n_exp);
            done = 1;
          end
          @(negedge clk);
        end
      end
    end

    in_valid = 1'b0;
    #1;
    chk(!out_valid && !in_ready, "R1", "quiet after traffic", out_valid, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule